// File: doc/BRIEF.md
# Streaming Low-Pass FIR Filter (32 taps, signed Q7.8)

This block smooths a stream of signed fixed-point samples. A producer presents one 16-bit two's-complement sample per clock, qualified by `in_valid`. The filter keeps a window of the 32 most recent accepted samples. For every accepted sample it forms the weighted sum of that window with 32 fixed coefficients. The full-precision result is rounded and clamped back to the input format, and it leaves on `out_sample` with a one-cycle `out_valid` strobe.

No output appears until the window has been completely filled since reset. From then on, each accepted sample yields exactly one result. A downstream stage can therefore count `out_valid` pulses to group consecutive results. When the producer pauses, the window holds its contents and the output side goes quiet. The coefficient set is a parameter, so one netlist can be built with any low-pass response.

Top module: `fir_lowpass32`

## Requirements
- R1: `rst` is asynchronous and active-high. While it is high, `out_valid` is 0, `out_sample` is 0, and the sample window and fill count are cleared, without waiting for a clock edge.
- R2: A sample is taken into the window on a rising edge of `clk` only when `in_valid` is high. Idle cycles neither shift the window nor change it, whatever `in_sample` carries.
- R3: After reset, the first 31 accepted samples produce no `out_valid`. The 32nd accepted sample, and every later one, produces exactly one output.
- R4: Each result is the sum over k = 0..31 of h(k)·x(n-k), where x(n) is the newest accepted sample. Coefficient h(k) is the signed Q7.8 value in bits [16k+15:16k] of parameter `COEFF`, so k = 0 multiplies the newest sample.
- R5: For a sample accepted on rising edge E, `out_valid` is high and `out_sample` carries its result from just after edge E+1 until edge E+2. Back-to-back accepted samples keep `out_valid` high continuously. An idle input cycle yields an idle output cycle.
- R6: The Q15.16 sum is rounded to Q7.8 by adding 2^7 and then discarding the low 8 bits. Exact halves therefore round toward plus infinity: +0.5 LSB gives +1 and -0.5 LSB gives 0.
- R7: A rounded result above 32767 is output as 16'h7FFF. A rounded result below -32768 is output as 16'h8000.
- R8: While `out_valid` is low, `out_sample` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_sample` for this cycle |
| in_sample | input | 16 | Signed Q7.8 input sample |
| out_valid | output | 1 | One-cycle strobe per filtered result |
| out_sample | output | 16 | Signed Q7.8 filtered result |

## Verification
A corrupted window entry shows up on the very next result. That entry is still weighted by some coefficient for up to 32 further outputs, so a single bad sample spoils a run of results rather than one. A wrong fill count moves the first `out_valid` earlier or later relative to the 32nd sample, so the bench counts strobes around that boundary. Rounding and clamping faults only appear on chosen values: exact halves of both signs, and windows full of the extreme codes.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int unsigned SAMPLE_W = 16;
  localparam int unsigned FRAC_W   = 8;
  localparam int unsigned TAPS_DEF = 32;

  // Triangular default response: small positive weights peaking mid-window.
  function automatic logic [TAPS_DEF*SAMPLE_W-1:0] tri_coeffs();
    logic [TAPS_DEF*SAMPLE_W-1:0] v;
    v = '0;
    for (int k = 0; k < TAPS_DEF; k++) begin
      if (k < TAPS_DEF / 2) v[k*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(k + 1);
      else                  v[k*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(TAPS_DEF - k);
    end
    return v;
  endfunction
endpackage

// File: rtl/fir_fill_count.sv
module fir_fill_count #(
  parameter int unsigned TAPS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  output logic primed
);
  localparam int unsigned CNT_W = $clog2(TAPS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TAPS);
  localparam logic [CNT_W-1:0] ALMOST = CNT_W'(TAPS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && (cnt_q != LIMIT)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // The sample arriving now completes (or extends) a full window.
  assign primed = (cnt_q >= ALMOST);
endmodule

// File: rtl/fir_history.sv
module fir_history #(
  parameter int unsigned TAPS = 32,
  parameter int unsigned DW   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic [DW-1:0]      din,
  output logic [TAPS*DW-1:0] window
);
  logic [TAPS*DW-1:0] win_q, win_d;

  // Newest sample sits in the lowest slot.
  always_comb begin
    win_d = win_q;
    if (shift_en) win_d = {win_q[(TAPS-1)*DW-1:0], din};
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) win_q <= '0;
    else     win_q <= win_d;
  end

  assign window = win_q;
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int unsigned TAPS  = 32,
  parameter int unsigned DW    = 16,
  parameter int unsigned ACC_W = 37,
  parameter logic [TAPS*DW-1:0] COEFF = '0
) (
  input  logic [TAPS*DW-1:0]     window,
  output logic signed [ACC_W-1:0] acc
);
  localparam int unsigned PROD_W = 2 * DW;

  logic signed [PROD_W-1:0] prod [TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    localparam logic signed [DW-1:0] H = COEFF[k*DW +: DW];
    assign prod[k] = $signed(window[k*DW +: DW]) * H;
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) begin
      acc = acc + {{(ACC_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
    end
  end
endmodule

// File: rtl/fir_round_sat.sv
module fir_round_sat #(
  parameter int unsigned ACC_W  = 37,
  parameter int unsigned DW     = 16,
  parameter int unsigned FRAC_W = 8
) (
  input  logic signed [ACC_W-1:0] acc,
  output logic        [DW-1:0]    y
);
  localparam int unsigned EXT_W = ACC_W + 1;
  localparam int unsigned SHR_W = EXT_W - FRAC_W;
  localparam logic signed [EXT_W-1:0] HALF = EXT_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [SHR_W-1:0] MAXV = SHR_W'((1 << (DW - 1)) - 1);
  localparam logic signed [SHR_W-1:0] MINV = -SHR_W'(1 << (DW - 1));

  logic signed [EXT_W-1:0] biased;
  logic signed [SHR_W-1:0] shifted;

  always_comb begin
    biased  = {acc[ACC_W-1], acc} + HALF;
    shifted = biased[EXT_W-1:FRAC_W];
    if (shifted > MAXV)      y = {1'b0, {(DW-1){1'b1}}};
    else if (shifted < MINV) y = {1'b1, {(DW-1){1'b0}}};
    else                     y = shifted[DW-1:0];
  end
endmodule

// File: rtl/fir_lowpass32.sv
module fir_lowpass32 #(
  parameter int unsigned TAPS   = fir_pkg::TAPS_DEF,
  parameter int unsigned DW     = fir_pkg::SAMPLE_W,
  parameter int unsigned FRAC_W = fir_pkg::FRAC_W,
  parameter logic [TAPS*DW-1:0] COEFF = fir_pkg::tri_coeffs()
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  output logic          out_valid,
  output logic [DW-1:0] out_sample
);
  localparam int unsigned ACC_W = 2 * DW + $clog2(TAPS);

  logic               primed;
  logic [TAPS*DW-1:0] window;
  logic signed [ACC_W-1:0] acc;
  logic [DW-1:0]      rounded;

  logic          win_vld_q, win_vld_d;
  logic          ov_q, ov_d;
  logic [DW-1:0] os_q, os_d;

  fir_fill_count #(.TAPS(TAPS)) u_fill (
    .clk(clk), .rst(rst), .inc(in_valid), .primed(primed)
  );

  fir_history #(.TAPS(TAPS), .DW(DW)) u_hist (
    .clk(clk), .rst(rst), .shift_en(in_valid), .din(in_sample), .window(window)
  );

  fir_mac #(.TAPS(TAPS), .DW(DW), .ACC_W(ACC_W), .COEFF(COEFF)) u_mac (
    .window(window), .acc(acc)
  );

  fir_round_sat #(.ACC_W(ACC_W), .DW(DW), .FRAC_W(FRAC_W)) u_rs (
    .acc(acc), .y(rounded)
  );

  always_comb begin
    win_vld_d = in_valid && primed;
    ov_d      = win_vld_q;
    os_d      = os_q;
    if (win_vld_q) os_d = rounded;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      win_vld_q <= 1'b0;
      ov_q      <= 1'b0;
      os_q      <= '0;
    end else begin
      win_vld_q <= win_vld_d;
      ov_q      <= ov_d;
      os_q      <= os_d;
    end
  end

  assign out_valid  = ov_q;
  assign out_sample = os_q;
endmodule

// File: rtl/fir_lowpass32_chk.sv
module fir_lowpass32_chk #(
  parameter int unsigned TAPS = 32,
  parameter int unsigned DW   = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          out_valid,
  input logic [DW-1:0] out_sample
);
  localparam int unsigned SEEN_W = $clog2(TAPS + 1);
  logic [SEEN_W-1:0] seen_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) seen_q <= '0;
    else if (in_valid && (seen_q != SEEN_W'(TAPS))) seen_q <= seen_q + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> (!out_valid && out_sample == '0));

  // R3
  fill_before_output_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (seen_q >= SEEN_W'(TAPS)));

  // R5
  valid_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_sample));
endmodule

bind fir_lowpass32 fir_lowpass32_chk #(.TAPS(TAPS), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/test_fir_lowpass32.sv
module test_fir_lowpass32;
  localparam int NT = 32;

  function automatic logic [NT*16-1:0] mk_coef();
    logic [NT*16-1:0] v;
    for (int k = 0; k < NT; k++) v[k*16 +: 16] = 16'(k + 1);
    return v;
  endfunction
  localparam logic [NT*16-1:0] BCOEF = mk_coef();

  // {valid, sample}
  localparam logic [16:0] STIM [40] = '{
    17'h1_0100, 17'h1_0280, 17'h1_FF00, 17'h1_0040, 17'h1_1234, 17'h1_F800, 17'h1_0333, 17'h1_00FF,
    17'h1_0A00, 17'h1_FFF1, 17'h1_0101, 17'h1_E000, 17'h1_0777, 17'h1_0010, 17'h1_FC18, 17'h1_0200,
    17'h1_2000, 17'h1_DEAD, 17'h1_0001, 17'h1_FFFF, 17'h1_0555, 17'h1_F0F0, 17'h1_0180, 17'h1_0C00,
    17'h1_FE80, 17'h1_0123, 17'h1_3000, 17'h1_C000, 17'h1_0066, 17'h1_0F00, 17'h1_FFA0, 17'h1_0400,
    17'h0_7777, 17'h1_0300, 17'h1_FD00, 17'h1_0050, 17'h0_8888, 17'h0_1111, 17'h1_0700, 17'h1_F900
  };

  logic clk, rst, in_valid;
  logic [15:0] in_sample;
  logic out_valid;
  logic [15:0] out_sample;

  int n_tests, n_fail;
  int hist [NT];
  int fill;
  bit st1_v, oexp_v;
  int st1_d, oexp_d;
  logic [15:0] last_out;

  fir_lowpass32 #(.COEFF(BCOEF)) i_fir_lowpass32 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int model_y();
    longint acc;
    acc = 0;
    for (int k = 0; k < NT; k++) acc += longint'(k + 1) * longint'(hist[k]);
    acc = (acc + 128) >>> 8;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  function automatic void model_reset();
    for (int k = 0; k < NT; k++) hist[k] = 0;
    fill = 0; st1_v = 0; oexp_v = 0; st1_d = 0; oexp_d = 0; last_out = '0;
  endfunction

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(input bit v, input logic [15:0] s);
    in_valid = v; in_sample = s;
    @(posedge clk);
    oexp_v = st1_v; oexp_d = st1_d;
    if (v) begin
      for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = int'($signed(s));
      if (fill < NT) fill++;
      st1_v = (fill >= NT);
      st1_d = model_y();
    end else st1_v = 0;
    @(negedge clk);
    chk(out_valid == oexp_v, "R5 valid", int'(out_valid), int'(oexp_v));
    if (oexp_v) chk(out_sample == 16'(oexp_d), "R4 data", int'(out_sample), oexp_d & 16'hFFFF);
    else chk(out_sample == last_out, "R8 hold", int'(out_sample), int'(last_out));
    last_out = out_sample;
  endtask

  task automatic do_reset();
    #2 rst = 1'b1;
    #1;
    chk(!out_valid && out_sample == 16'h0, "R1 async clear", int'(out_sample), 0);
    model_reset();
    in_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #2000000;
    n_fail++; n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int nvalid;
    n_tests = 0; n_fail = 0;
    rst = 1'b1; in_valid = 1'b0; in_sample = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk(!out_valid && out_sample == 16'h0, "R1 reset state", int'(out_sample), 0);
    rst = 1'b0;

    // Table walk: fill boundary, gaps, general data.
    nvalid = 0;
    for (int i = 0; i < 40; i++) begin
      step(STIM[i][16], STIM[i][15:0]);
      if (out_valid) nvalid++;
      if (i == 30) chk(nvalid == 0, "R3 silent 31", nvalid, 0);
      if (i == 32) chk(out_valid == 1'b1, "R3 first out", int'(out_valid), 1);
    end
    for (int i = 0; i < 3; i++) step(1'b0, 16'h0);

    // R2: idle cycles with changing data leave the window untouched.
    do_reset();
    for (int i = 0; i < NT; i++) step(1'b1, 16'(i * 37));
    for (int i = 0; i < 6; i++) step(1'b0, 16'(16'hBEEF + i * 911));
    step(1'b1, 16'h0042);
    step(1'b0, 16'h5A5A);
    chk(out_valid && out_sample == 16'(model_y()), "R2 window kept", int'(out_sample), model_y() & 16'hFFFF);

    // R6: exact halves round upward.
    do_reset();
    for (int i = 0; i < NT - 1; i++) step(1'b1, 16'h0);
    step(1'b1, 16'h0080);
    step(1'b0, 16'h0);
    chk(out_sample == 16'h0001, "R6 +half", int'(out_sample), 1);
    step(1'b1, 16'hFF80);
    step(1'b0, 16'h0);
    chk(out_sample == 16'h0001, "R6 -half", int'(out_sample), 1);
    do_reset();
    for (int i = 0; i < NT - 1; i++) step(1'b1, 16'h0);
    step(1'b1, 16'hFF80);
    step(1'b0, 16'h0);
    chk(out_sample == 16'h0000, "R6 -half to 0", int'(out_sample), 0);
    do_reset();
    for (int i = 0; i < NT - 1; i++) step(1'b1, 16'h0);
    step(1'b1, 16'h0180);
    step(1'b0, 16'h0);
    chk(out_sample == 16'h0002, "R6 1.5 to 2", int'(out_sample), 2);

    // R7: clamp at both ends.
    do_reset();
    for (int i = 0; i < NT; i++) step(1'b1, 16'h7FFF);
    step(1'b0, 16'h0);
    chk(out_sample == 16'h7FFF, "R7 pos clamp", int'(out_sample), 16'h7FFF);
    for (int i = 0; i < NT; i++) step(1'b1, 16'h8000);
    step(1'b0, 16'h0);
    chk(out_sample == 16'h8000, "R7 neg clamp", int'(out_sample), 16'h8000);

    // R1/R3: reset mid-stream clears fill; refill is silent again.
    for (int i = 0; i < 5; i++) step(1'b1, 16'(i * 300));
    do_reset();
    nvalid = 0;
    for (int i = 0; i < NT - 1; i++) begin
      step(1'b1, 16'(16'h0100 + i));
      if (out_valid) nvalid++;
    end
    step(1'b1, 16'h0011);
    if (out_valid) nvalid++;
    chk(nvalid == 0, "R3 refill silent", nvalid, 0);
    step(1'b1, 16'h0022);
    chk(out_valid == 1'b1, "R3 refill first", int'(out_valid), 1);
    step(1'b0, 16'h0);
    step(1'b0, 16'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule